// File: doc/BRIEF.md
# SYSREF-Aligned Extended Multiblock Counter

This block keeps the link-clock counter that marks extended multiblock boundaries on the transmit side of a high-speed serial converter link. The counter runs from 0 up to E*32-1 and wraps. E is the number of multiblocks in an extended multiblock, supplied as E-1 on `emb_cnt_m1_i`. When an enabled rising edge of the already-synchronised SYSREF reference arrives, the counter is reloaded with a programmable phase offset. This lets the system shift the reference edge to absorb board-level skew between the converter and the link logic.

Two realignment modes exist. The one-shot mode has an enable that comes out of reset set. Software can re-arm it with a set pulse, and the block drops it by itself once it has acted on an edge. The continuous mode realigns on every rising edge. In that mode the block also flags any reference edge whose spacing is not a whole number of extended multiblocks. The boundary marker stays suppressed, and a pending status stays high, until the block has acted on at least one reference edge. A link restart request clears the counter but does not forget that the reference has been seen. The error pulse feeds an external error-status block.

Top module: `emc_align`

## Requirements
- R1: With no realignment, `emc_o` increases by one each clock and returns to 0 after reaching E*32-1, where E = `emb_cnt_m1_i`+1.
- R2: While `rst_n` is low and right after it, `emc_o` is 0, `oneshot_en_o` is 1, `await_ref_o` is 1, `emb_end_o` is 0 and `ref_err_o` is 0.
- R3: A reference edge is a cycle in which `sysref_i` is 1 and was 0 in the previous cycle; holding `sysref_i` high produces no further edge.
- R4: An edge arriving while `oneshot_en_o` or `contin_en_i` is 1 makes `emc_o` equal to `align_ofs_i` (zero-extended) in the next cycle.
- R5: `oneshot_en_o` drops to 0 in the cycle after it caused a realignment, and becomes 1 after a cycle with `oneshot_set_i` high; a set in the same cycle as a realigning edge leaves it at 1.
- R6: With `contin_en_i` at 1, every edge realigns the counter, whatever the state of `oneshot_en_o`.
- R7: With `oneshot_en_o` and `contin_en_i` both 0, edges are ignored and the counter keeps free-running.
- R8: `ref_err_o` pulses for one cycle, in the cycle after an edge, when `contin_en_i` is 1, a reference edge has already been seen, and the counter's free-running next value differs from `align_ofs_i`; edge spacings that are multiples of E*32 raise no error.
- R9: `emb_end_o` is 1 exactly in cycles where `emc_o` equals E*32-1 and a reference edge has been seen since reset.
- R10: `await_ref_o` is 1 from reset until the cycle after the first realigning edge, and is 0 from then on.
- R11: A cycle with `relink_i` high sets `emc_o` to 0 in the next cycle, taking priority over realignment and suppressing the error pulse, and leaves `await_ref_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sysref_i | input | 1 | Reference, already synchronised to `clk` |
| emb_cnt_m1_i | input | E_W | Multiblocks per extended multiblock, minus one |
| align_ofs_i | input | OFS_W | Counter value loaded on a realigning edge |
| oneshot_set_i | input | 1 | Pulse that re-arms one-shot realignment |
| contin_en_i | input | 1 | Continuous realignment and period checking |
| relink_i | input | 1 | Link restart request |
| emc_o | output | E_W+5 | Extended multiblock counter |
| emb_end_o | output | 1 | Last cycle of an extended multiblock |
| oneshot_en_o | output | 1 | One-shot realignment armed |
| await_ref_o | output | 1 | No reference edge acted on yet |
| ref_err_o | output | 1 | Reference period mismatch pulse |

## Verification
The hardest situation to reach is a continuous-mode edge that lands exactly one extended-multiblock multiple after the previous one, as opposed to one cycle early or late. That difference is all that separates a silent realignment from an error pulse. The stimulus counts clocks from each sampled realignment and raises the reference after chosen gaps (32, 64, 96, 33, 31, 40). It predicts the error as the gap modulo E*32. A second hard case is a one-shot set that coincides with a realigning edge, which needs an armed enable plus a fresh edge in the same cycle. That case is reached by re-arming first and then issuing both together.

// File: rtl/emc_pkg.sv
package emc_pkg;

    // log2 of the number of link clocks per multiblock
    localparam int EMB_SHIFT = 5;

    typedef struct packed {
        logic prev;
    } edge_state_t;

    typedef struct packed {
        logic oneshot;
        logic seen;
        logic err;
    } ref_state_t;

endpackage

// File: rtl/emc_edge_det.sv
module emc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic edge_o
);
    import emc_pkg::*;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = ref_i;
        edge_o    = ref_i & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: no edge while the reference was already high
    a_r3_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_i && edge_o) |=> (ref_i ? !edge_o : 1'b1));
endmodule

// File: rtl/emc_counter.sv
module emc_counter #(
    parameter  int E_W   = 8,
    parameter  int OFS_W = 8,
    localparam int CNT_W = E_W + emc_pkg::EMB_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [E_W-1:0]   emb_m1_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             load_i,
    input  logic             clear_i,
    input  logic             seen_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] free_nxt_o,
    output logic             end_o
);
    import emc_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last       = {emb_m1_i, {EMB_SHIFT{1'b1}}};
        free_nxt_o = (st_q.cnt >= last) ? '0 : st_q.cnt + 1'b1;
        st_d       = st_q;
        if (clear_i)     st_d.cnt = '0;
        else if (load_i) st_d.cnt = CNT_W'(ofs_i);
        else             st_d.cnt = free_nxt_o;
        cnt_o = st_q.cnt;
        end_o = seen_i && (st_q.cnt == last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: wrap to zero at the last count
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == last && !load_i && !clear_i) |=> cnt_o == '0);
    // R4: realignment loads the offset
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) |=> cnt_o == CNT_W'($past(ofs_i)));
    // R11: restart clears the counter
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> cnt_o == '0);
endmodule

// File: rtl/emc_ref_mon.sv
module emc_ref_mon #(
    parameter int OFS_W = 8,
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             set_i,
    input  logic             contin_i,
    input  logic             relink_i,
    input  logic [CNT_W-1:0] free_nxt_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic             load_o,
    output logic             oneshot_o,
    output logic             seen_o,
    output logic             err_o
);
    import emc_pkg::*;

    ref_state_t st_d, st_q;

    always_comb begin
        load_o = edge_i & (st_q.oneshot | contin_i);
        st_d   = st_q;
        if (set_i)       st_d.oneshot = 1'b1;
        else if (load_o) st_d.oneshot = 1'b0;
        st_d.seen = st_q.seen | load_o;
        st_d.err  = edge_i & contin_i & st_q.seen & ~relink_i
                  & (free_nxt_i != CNT_W'(ofs_i));
        oneshot_o = st_q.oneshot;
        seen_o    = st_q.seen;
        err_o     = st_q.err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{oneshot: 1'b1, seen: 1'b0, err: 1'b0};
        else        st_q <= st_d;
    end

    // R5: one-shot enable drops after acting without a set
    a_r5_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && !set_i) |=> !oneshot_o);
    // R10: detection record is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seen_o |=> seen_o);
    // R8: period errors only come from continuous mode
    a_r8_err_mode: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(contin_i));
endmodule

// File: rtl/emc_align.sv
module emc_align #(
    parameter  int E_W   = 8,
    parameter  int OFS_W = 8,
    localparam int CNT_W = E_W + emc_pkg::EMB_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sysref_i,
    input  logic [E_W-1:0]   emb_cnt_m1_i,
    input  logic [OFS_W-1:0] align_ofs_i,
    input  logic             oneshot_set_i,
    input  logic             contin_en_i,
    input  logic             relink_i,
    output logic [CNT_W-1:0] emc_o,
    output logic             emb_end_o,
    output logic             oneshot_en_o,
    output logic             await_ref_o,
    output logic             ref_err_o
);
    import emc_pkg::*;

    logic             ref_edge;
    logic             do_load;
    logic             seen;
    logic [CNT_W-1:0] free_nxt;

    emc_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (sysref_i),
        .edge_o (ref_edge)
    );

    emc_ref_mon #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_i     (ref_edge),
        .set_i      (oneshot_set_i),
        .contin_i   (contin_en_i),
        .relink_i   (relink_i),
        .free_nxt_i (free_nxt),
        .ofs_i      (align_ofs_i),
        .load_o     (do_load),
        .oneshot_o  (oneshot_en_o),
        .seen_o     (seen),
        .err_o      (ref_err_o)
    );

    emc_counter #(.E_W(E_W), .OFS_W(OFS_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .emb_m1_i   (emb_cnt_m1_i),
        .ofs_i      (align_ofs_i),
        .load_i     (do_load),
        .clear_i    (relink_i),
        .seen_i     (seen),
        .cnt_o      (emc_o),
        .free_nxt_o (free_nxt),
        .end_o      (emb_end_o)
    );

    assign await_ref_o = ~seen;

    // R9: boundary marker withheld until the reference is seen
    a_r9_end_gated: assert property (@(posedge clk) disable iff (!rst_n)
        emb_end_o |-> !await_ref_o);
    // R7: with both enables off the counter free-runs
    a_r7_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (!oneshot_en_o && !contin_en_i && !relink_i
         && emc_o < {emb_cnt_m1_i, {EMB_SHIFT{1'b1}}})
        |=> emc_o == $past(emc_o) + 1'b1);
endmodule

// File: tb/emc_align_bench.sv
module emc_align_bench;
    localparam int E_W   = 8;
    localparam int OFS_W = 8;
    localparam int CNT_W = E_W + 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sysref_i = 1'b0;
    logic [E_W-1:0]   emb_cnt_m1_i = '0;
    logic [OFS_W-1:0] align_ofs_i = '0;
    logic             oneshot_set_i = 1'b0;
    logic             contin_en_i = 1'b0;
    logic             relink_i = 1'b0;
    logic [CNT_W-1:0] emc_o;
    logic             emb_end_o, oneshot_en_o, await_ref_o, ref_err_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    emc_align #(.E_W(E_W), .OFS_W(OFS_W)) u_emc_align (
        .clk(clk), .rst_n(rst_n), .sysref_i(sysref_i),
        .emb_cnt_m1_i(emb_cnt_m1_i), .align_ofs_i(align_ofs_i),
        .oneshot_set_i(oneshot_set_i), .contin_en_i(contin_en_i),
        .relink_i(relink_i), .emc_o(emc_o), .emb_end_o(emb_end_o),
        .oneshot_en_o(oneshot_en_o), .await_ref_o(await_ref_o),
        .ref_err_o(ref_err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int per;
        int since;
        int cprev;
        int gaps[6];
        gaps = '{32, 64, 96, 33, 31, 40};

        repeat (3) tick();
        chk("R2 cnt", int'(emc_o), 0);
        chk("R2 oneshot", int'(oneshot_en_o), 1);
        chk("R2 await", int'(await_ref_o), 1);
        chk("R2 end", int'(emb_end_o), 0);
        chk("R2 err", int'(ref_err_o), 0);
        rst_n = 1'b1;

        // R1 free run, R9 marker withheld, R10 pending held
        for (int j = 1; j <= 70; j++) begin
            tick();
            chk("R1 free cnt", int'(emc_o), j % 32);
            chk("R9 end before seen", int'(emb_end_o), 0);
            chk("R10 pending", int'(await_ref_o), 1);
        end

        // one-shot sweep over E and offsets
        for (int e = 0; e < 3; e++) begin
            for (int oi = 0; oi < 3; oi++) begin
                int o;
                per = (e + 1) * 32;
                o = (oi == 0) ? 0 : (oi == 1) ? 13 : per - 1;
                emb_cnt_m1_i = E_W'(e);
                align_ofs_i  = OFS_W'(o);
                oneshot_set_i = 1'b1;
                tick();
                oneshot_set_i = 1'b0;
                chk("R5 rearm", int'(oneshot_en_o), 1);
                repeat (e * 7 + 3) tick();
                sysref_i = 1'b1;
                tick();
                chk("R4 load", int'(emc_o), o);
                chk("R5 autoclear", int'(oneshot_en_o), 0);
                chk("R10 seen", int'(await_ref_o), 0);
                for (int k = 1; k <= per + 5; k++) begin
                    int ex;
                    if (k == 3) sysref_i = 1'b0;
                    if (k == per / 2) sysref_i = 1'b1;
                    if (k == per / 2 + 2) sysref_i = 1'b0;
                    tick();
                    ex = (o + k) % per;
                    chk("R7 R1 cnt", int'(emc_o), ex);
                    chk("R9 end", int'(emb_end_o), (ex == per - 1) ? 1 : 0);
                    chk("R8 no err", int'(ref_err_o), 0);
                end
                sysref_i = 1'b0;
            end
        end

        // continuous mode, R3 held high
        emb_cnt_m1_i = '0;
        align_ofs_i  = 8'd7;
        contin_en_i  = 1'b1;
        tick();
        cprev = int'(emc_o);
        sysref_i = 1'b1;
        tick();
        chk("R6 load", int'(emc_o), 7);
        chk("R8 first err", int'(ref_err_o), (((cprev + 1) % 32) != 7) ? 1 : 0);
        since = 0;
        for (int k = 1; k <= 20; k++) begin
            tick();
            since++;
            chk("R3 held", int'(emc_o), (7 + k) % 32);
            chk("R3 err", int'(ref_err_o), 0);
        end
        for (int g = 0; g < 6; g++) begin
            sysref_i = 1'b0;
            while (since < gaps[g] - 1) begin
                tick();
                since++;
            end
            sysref_i = 1'b1;
            tick();
            since = 0;
            chk("R6 realign", int'(emc_o), 7);
            chk("R8 period", int'(ref_err_o), (gaps[g] % 32 != 0) ? 1 : 0);
            sysref_i = 1'b0;
        end
        tick();
        chk("R8 pulse", int'(ref_err_o), 0);
        contin_en_i = 1'b0;

        // R5 set coincident with edge
        align_ofs_i = 8'd20;
        oneshot_set_i = 1'b1;
        tick();
        chk("R5 set", int'(oneshot_en_o), 1);
        sysref_i = 1'b1;
        tick();
        oneshot_set_i = 1'b0;
        chk("R4 load coincident", int'(emc_o), 20);
        chk("R5 set wins", int'(oneshot_en_o), 1);
        sysref_i = 1'b0;
        tick();
        tick();
        sysref_i = 1'b1;
        tick();
        chk("R4 load again", int'(emc_o), 20);
        chk("R5 cleared", int'(oneshot_en_o), 0);
        sysref_i = 1'b0;
        tick();

        // R11 restart
        relink_i = 1'b1;
        tick();
        relink_i = 1'b0;
        chk("R11 clear", int'(emc_o), 0);
        chk("R11 seen kept", int'(await_ref_o), 0);
        tick();
        chk("R11 resume", int'(emc_o), 1);
        contin_en_i = 1'b1;
        sysref_i = 1'b1;
        relink_i = 1'b1;
        tick();
        relink_i = 1'b0;
        sysref_i = 1'b0;
        chk("R11 priority", int'(emc_o), 0);
        chk("R11 no err", int'(ref_err_o), 0);
        tick();
        chk("R11 next", int'(emc_o), 1);
        contin_en_i = 1'b0;

        rst_n = 1'b0;
        tick();
        chk("R2 reset pending", int'(await_ref_o), 1);
        chk("R2 reset oneshot", int'(oneshot_en_o), 1);
        chk("R2 reset cnt", int'(emc_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule